// File: doc/BRIEF.md
# Dual-Mode Pixel Bus Capture

This block sits at the edge of a display transmitter and takes in the parallel pixel bus from a graphics controller. Each clock cycle it presents one 24-bit pixel together with its data-enable, horizontal sync and vertical sync. All four are registered on the rising clock edge.

Two capture schemes are supported:

- **Half-width dual-edge.** The controller sends a 12-bit half-pixel on each clock edge. The block joins the two halves into one pixel.
- **Full-width single-edge.** The controller sends the whole 24-bit word once per cycle. A polarity input chooses whether the word is taken on the rising or the falling edge.

The mode and polarity pins are static configuration. The latency from capture to output is the same in every mode, so logic further down does not depend on the mode.

The output is a valid-only stream, and `pix_de` acts as its valid flag. There is no ready input and no back-pressure. The controller cannot be stalled, so every pixel is presented for exactly one cycle, and the consumer must accept it in that cycle.

Top module: `pxcap_top`

## Requirements
- R1: `mode_dual` = 1 selects half-width dual-edge capture. `mode_dual` = 0 selects full-width single-edge capture.
- R2: In dual-edge mode, `pin_data[11:0]` taken at a rising edge becomes pixel bits 11:0. `pin_data[11:0]` taken at the falling edge that follows becomes pixel bits 23:12.
- R3: In single-edge mode with `edge_rise` = 1, all 24 data bits and de/hsync/vsync are taken at the rising edge.
- R4: In single-edge mode with `edge_rise` = 0, all 24 data bits and de/hsync/vsync are taken at the falling edge.
- R5: In dual-edge mode, de/hsync/vsync are taken at the rising edge only. Their values at the falling edge have no effect on the output.
- R6: In dual-edge mode, `pin_data[23:12]` and `edge_rise` have no effect on the output.
- R7: A pixel whose capture begins at rising edge k (rising capture at k, falling capture in the half-cycle after k) appears on the outputs after rising edge k+1, in every mode.
- R8: A rising edge with `rst` = 1 clears `pix_data` to zero and drives `pix_de`, `pix_hs` and `pix_vs` low.
- R9: The outputs change only at rising edges. They hold steady across a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_dual | input | 1 | 1: half-width dual-edge, 0: full-width single-edge |
| edge_rise | input | 1 | Single-edge mode: 1 rising, 0 falling |
| pin_data | input | 24 | Pixel bus data |
| pin_de | input | 1 | Data enable from the controller |
| pin_hs | input | 1 | Horizontal sync from the controller |
| pin_vs | input | 1 | Vertical sync from the controller |
| pix_data | output | 24 | Captured pixel |
| pix_de | output | 1 | Pixel valid / data enable |
| pix_hs | output | 1 | Horizontal sync, aligned with the pixel |
| pix_vs | output | 1 | Vertical sync, aligned with the pixel |

## Verification
The hardest case to reach is proving that the falling-edge half of a cycle is used in the right place and ignored in the right place. The output never shows directly which edge supplied which bits. The stimulus therefore drives one value just before each rising edge and a deliberately different value, including different control bits and upper data bits, just before the following falling edge. Each expected pixel then identifies which edge each field came from. The output is also sampled again just after the falling edge, which shows that nothing moves at that edge.

// File: rtl/pxcap_pkg.sv
package pxcap_pkg;

  // Control bits that travel with every pixel.
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Which captured sample feeds the output register.
  typedef enum logic [1:0] {
    PATH_JOIN = 2'd0,  // low half from rising edge, high half from falling edge
    PATH_RISE = 2'd1,  // full word from rising edge
    PATH_FALL = 2'd2   // full word from falling edge
  } path_e;

endpackage

// File: rtl/pxcap_edge_reg.sv
// Capture register clocked on a chosen edge of the bus clock.
module pxcap_edge_reg #(
  parameter int W       = 27,
  parameter bit ON_FALL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/pxcap_path_sel.sv
// Decodes the configuration pins into an output path.
module pxcap_path_sel
  import pxcap_pkg::*;
(
  input  logic  mode_dual,
  input  logic  edge_rise,
  output path_e path
);

  always_comb begin
    if (mode_dual)      path = PATH_JOIN;   // polarity pin unused here
    else if (edge_rise) path = PATH_RISE;
    else                path = PATH_FALL;
  end

endmodule

// File: rtl/pxcap_assemble.sv
// Builds the output pixel from the two capture stages and registers it
// on the rising edge.
module pxcap_assemble
  import pxcap_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int PIX_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  path_e            path,
  input  logic [PIX_W-1:0] rise_word,
  input  ctl_t             rise_ctl,
  input  logic [PIX_W-1:0] fall_word,
  input  ctl_t             fall_ctl,
  output logic [PIX_W-1:0] pix_word,
  output ctl_t             pix_ctl
);

  logic [PIX_W-1:0] nxt_word;
  ctl_t             nxt_ctl;

  always_comb begin
    nxt_word = '0;
    nxt_ctl  = '0;
    case (path)
      PATH_JOIN: begin
        nxt_word = {fall_word[HALF_W-1:0], rise_word[HALF_W-1:0]};
        nxt_ctl  = rise_ctl;
      end
      PATH_RISE: begin
        nxt_word = rise_word;
        nxt_ctl  = rise_ctl;
      end
      PATH_FALL: begin
        nxt_word = fall_word;
        nxt_ctl  = fall_ctl;
      end
      default: begin
        nxt_word = '0;
        nxt_ctl  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_word <= '0;
      pix_ctl  <= '0;
    end else begin
      pix_word <= nxt_word;
      pix_ctl  <= nxt_ctl;
    end
  end

  // R8: reset clears the pixel and its control bits.
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (pix_word == '0 && pix_ctl == '0));

  // R2: in the joined path the high half follows the falling-edge stage.
  p_hi_half_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(path) == PATH_JOIN && !$past(rst))
      |-> pix_word[PIX_W-1:HALF_W] == $past(fall_word[HALF_W-1:0]));

  // R4: the falling path takes the full falling-edge sample.
  p_fall_full_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(path) == PATH_FALL && !$past(rst))
      |-> (pix_word == $past(fall_word) && pix_ctl == $past(fall_ctl)));

endmodule

// File: rtl/pxcap_top.sv
// Dual-mode pixel bus capture, top level.
module pxcap_top
  import pxcap_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int PIX_W = 2 * HALF_W,
  localparam int CAP_W = PIX_W + CTL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_dual,
  input  logic             edge_rise,
  input  logic [PIX_W-1:0] pin_data,
  input  logic             pin_de,
  input  logic             pin_hs,
  input  logic             pin_vs,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_de,
  output logic             pix_hs,
  output logic             pix_vs
);

  logic [CAP_W-1:0] bus_in;
  logic [CAP_W-1:0] rise_q;
  logic [CAP_W-1:0] fall_q;
  path_e            path;
  ctl_t             out_ctl;

  assign bus_in = {pin_de, pin_hs, pin_vs, pin_data};

  pxcap_edge_reg #(.W(CAP_W), .ON_FALL(1'b0)) u_rise (
    .clk(clk), .rst(rst), .d(bus_in), .q(rise_q)
  );

  pxcap_edge_reg #(.W(CAP_W), .ON_FALL(1'b1)) u_fall (
    .clk(clk), .rst(rst), .d(bus_in), .q(fall_q)
  );

  pxcap_path_sel u_sel (
    .mode_dual(mode_dual), .edge_rise(edge_rise), .path(path)
  );

  pxcap_assemble #(.HALF_W(HALF_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .path     (path),
    .rise_word(rise_q[PIX_W-1:0]),
    .rise_ctl (ctl_t'(rise_q[CAP_W-1:PIX_W])),
    .fall_word(fall_q[PIX_W-1:0]),
    .fall_ctl (ctl_t'(fall_q[CAP_W-1:PIX_W])),
    .pix_word (pix_data),
    .pix_ctl  (out_ctl)
  );

  assign pix_de = out_ctl.de;
  assign pix_hs = out_ctl.hs;
  assign pix_vs = out_ctl.vs;

  // Cycles since reset, so that two-deep history only covers live inputs.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  logic settled;
  assign settled = (since_rst >= 2'd2);

  // R2, R7: low half comes from the bus two rising edges earlier.
  p_lo_half_r2: assert property (@(posedge clk) disable iff (rst)
    (settled && $past(mode_dual))
      |-> pix_data[HALF_W-1:0] == $past(pin_data[HALF_W-1:0], 2));

  // R5: dual-edge control bits follow the rising-edge pins only.
  p_dual_ctl_r5: assert property (@(posedge clk) disable iff (rst)
    (settled && $past(mode_dual))
      |-> {pix_de, pix_hs, pix_vs} == $past({pin_de, pin_hs, pin_vs}, 2));

  // R3, R7: rising single-edge path, one output stage after capture.
  p_rise_full_r3: assert property (@(posedge clk) disable iff (rst)
    (settled && $past(!mode_dual && edge_rise))
      |-> (pix_data == $past(pin_data, 2)
           && {pix_de, pix_hs, pix_vs} == $past({pin_de, pin_hs, pin_vs}, 2)));

endmodule

// File: tb/sim_pxcap_top.sv
module sim_pxcap_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_dual = 1'b0;
  logic        edge_rise = 1'b1;
  logic [23:0] pin_data = '0;
  logic        pin_de = 1'b0;
  logic        pin_hs = 1'b0;
  logic        pin_vs = 1'b0;
  logic [23:0] pix_data;
  logic        pix_de, pix_hs, pix_vs;

  always #4 clk = ~clk;  // 125 MHz

  pxcap_top u0 (
    .clk(clk), .rst(rst), .mode_dual(mode_dual), .edge_rise(edge_rise),
    .pin_data(pin_data), .pin_de(pin_de), .pin_hs(pin_hs), .pin_vs(pin_vs),
    .pix_data(pix_data), .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  // Control bits are ordered {de, hs, vs}.
  typedef struct packed {
    logic        mode;
    logic        edg;
    logic [23:0] rd;
    logic [2:0]  rc;
    logic [23:0] fd;
    logic [2:0]  fc;
    logic [23:0] xd;
    logic [2:0]  xc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    // R1 R2: dual, halves 123 then 456
    '{1'b1, 1'b1, 24'hABC123, 3'b100, 24'h000456, 3'b011, 24'h456123, 3'b100, 4'd2},
    // R6 R5: dual, edge pin low, upper bits junk, falling ctl ignored
    '{1'b1, 1'b0, 24'hFFF9A5, 3'b010, 24'hEEE0F0, 3'b101, 24'h0F09A5, 3'b010, 4'd6},
    // R1 R3: single rising edge
    '{1'b0, 1'b1, 24'h123456, 3'b101, 24'h654321, 3'b010, 24'h123456, 3'b101, 4'd3},
    // R4: single falling edge
    '{1'b0, 1'b0, 24'h111111, 3'b000, 24'hC0FFEE, 3'b111, 24'hC0FFEE, 3'b111, 4'd4},
    // R3: all zero on rising, all ones on falling
    '{1'b0, 1'b1, 24'h000000, 3'b011, 24'hFFFFFF, 3'b100, 24'h000000, 3'b011, 4'd3},
    // R4: extreme bits on falling
    '{1'b0, 1'b0, 24'hFFFFFF, 3'b111, 24'h800001, 3'b001, 24'h800001, 3'b001, 4'd4},
    // R5: dual, ctl high only on falling edge
    '{1'b1, 1'b1, 24'h000FFF, 3'b000, 24'h000000, 3'b111, 24'h000FFF, 3'b000, 4'd5},
    // R2: dual, single bit at each half boundary
    '{1'b1, 1'b1, 24'h000001, 3'b111, 24'h000800, 3'b000, 24'h800001, 3'b111, 4'd2}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [26:0] act, input logic [26:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] outv();
    return {pix_de, pix_hs, pix_vs, pix_data};
  endfunction

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [26:0] hold;
    // R8: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(outv() == 27'd0, "R8 reset state", outv(), 27'd0);
    rst = 1'b0;
    @(negedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      mode_dual = VT[i].mode;
      edge_rise = VT[i].edg;
      pin_data  = VT[i].rd;
      {pin_de, pin_hs, pin_vs} = VT[i].rc;
      @(posedge clk);
      #1;
      pin_data  = VT[i].fd;
      {pin_de, pin_hs, pin_vs} = VT[i].fc;
      @(posedge clk);
      #1;
      // R7: same one-stage latency for every mode
      chk(outv() == {VT[i].xc, VT[i].xd},
          $sformatf("R%0d (R7 latency) vec %0d", VT[i].req, i),
          outv(), {VT[i].xc, VT[i].xd});
      hold = outv();
      @(negedge clk);
      #1;
      chk(outv() == hold, $sformatf("R9 stable at falling edge vec %0d", i),
          outv(), hold);
    end

    // R3 then R8: reset in the middle of live traffic
    mode_dual = 1'b0;
    edge_rise = 1'b1;
    pin_data  = 24'h5A5A5A;
    {pin_de, pin_hs, pin_vs} = 3'b100;
    @(posedge clk);
    #1;
    @(posedge clk);
    #1;
    chk(outv() == {3'b100, 24'h5A5A5A}, "R3 before mid reset",
        outv(), {3'b100, 24'h5A5A5A});
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(outv() == 27'd0, "R8 mid-stream reset", outv(), 27'd0);
    chk(pix_de == 1'b0, "R8 de low", {26'd0, pix_de}, 27'd0);
    rst = 1'b0;
    @(posedge clk);
    #1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule